// File: doc/BRIEF.md
# Half-Ratio Cache Clock Generator

This block takes a fast core clock and produces the clock for an external synchronous SRAM cache. A 3-bit ratio code sets the output period to 1, 1.5, 2, 2.5 or 3 core cycles, or stops the clock. Half-integer periods are built by deciding the output level for every half of a core cycle. The level for the high half comes from a rising-edge register. The level for the low half comes from a falling-edge register.

The block also handles the core's low-power states. When the clock-stop enable is set, the RAM clocks are held low while the core is in nap or sleep. The sync clock keeps running so that an external delay-locked loop stays in step. When the sleep-pin enable is set, a sleep pin to the SRAMs follows the nap/sleep status. A DLL-enable flag reports whether a valid running ratio is selected.

Top module: `halfratio_clkgen`

## Requirements
- R1: The ratio codes 001, 010, 100, 101 and 110 give an output period of 2, 3, 4, 5 and 6 core half-cycles. A period starts with a high level lasting floor(halves/2) half-cycles, and the level is low for the rest of the period.
- R2: Code 000 keeps sync_clk and both RAM clocks low. One core cycle after code 000 is sampled, dll_en is low. One core cycle after a valid nonzero code is sampled, dll_en is high.
- R3: The reserved codes 011 and 111 behave exactly like 000: all clocks stay low and dll_en is low.
- R4: While clk_stop_en is 1 and core_nap or core_sleep is 1, both RAM clocks are low from the next period boundary onward. During that time sync_clk keeps its normal waveform. The RAM clocks resume at the first period boundary after the gating condition ends.
- R5: A new ratio code, or a new gating decision, is adopted only at a period boundary. A boundary may fall at either edge of the core clock. No pulse is shortened.
- R6: When gating is not active, each RAM clock carries the same waveform as sync_clk.
- R7: ram_zz equals sleep_pin_en AND (core_nap OR core_sleep), delayed by one core cycle.
- R8: While rst_n is low, all outputs are low.
- R9: When clk_stop_en is 0, core_nap and core_sleep have no effect on the RAM clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 3 | Core-to-cache ratio selector |
| clk_stop_en | input | 1 | Gate the RAM clocks during nap or sleep |
| sleep_pin_en | input | 1 | Drive the SRAM sleep pin during nap or sleep |
| core_nap | input | 1 | Core is in nap |
| core_sleep | input | 1 | Core is in sleep |
| ram_clk | output | RAM_CLKS | Gated RAM clocks |
| sync_clk | output | 1 | Ungated feedback clock for delay tracking |
| dll_en | output | 1 | Valid running ratio selected |
| ram_zz | output | 1 | SRAM sleep pin |

## Verification
The assertions assume that the control inputs change only between rising edges of the core clock. They also assume these inputs are synchronous to that clock, so a ratio or gating request is seen as one clean value at each rising edge. The stimulus drives every input shortly after the falling edge, well clear of both edges. It changes the ratio at irregular intervals so that updates arrive at every phase of a running period, including phases whose boundary falls on a falling edge.

// File: rtl/hcg_pkg.sv
package hcg_pkg;
  localparam int MAX_HALVES = 6;
  localparam int PH_W = $clog2(MAX_HALVES + 1);
  localparam int CODE_W = 3;

  typedef logic [PH_W-1:0] halves_t;

  // Half-cycles per output period; reserved or zero codes give 0 (stopped).
  function automatic halves_t code_halves(input logic [CODE_W-1:0] code);
    case (code)
      3'b001:  return halves_t'(2);
      3'b010:  return halves_t'(3);
      3'b100:  return halves_t'(4);
      3'b101:  return halves_t'(5);
      3'b110:  return halves_t'(6);
      default: return halves_t'(0);
    endcase
  endfunction

  function automatic logic code_reserved(input logic [CODE_W-1:0] code);
    return (code == 3'b011) || (code == 3'b111);
  endfunction

  // Output level at half index i of a period of p halves.
  function automatic logic level_at(input halves_t p, input halves_t i);
    return (p != '0) && (i < (p >> 1));
  endfunction

  // Next half index, wrapping at p.
  function automatic halves_t next_idx(input halves_t p, input halves_t i);
    logic [PH_W:0] inc;
    inc = {1'b0, i} + 1'b1;
    if (p == '0 || inc >= {1'b0, p}) return '0;
    return inc[PH_W-1:0];
  endfunction
endpackage

// File: rtl/hcg_pwr_ctrl.sv
module hcg_pwr_ctrl
  import hcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic              clk_stop_en,
  input  logic              sleep_pin_en,
  input  logic              core_nap,
  input  logic              core_sleep,
  output halves_t           req_halves,
  output logic              req_ram_on,
  output logic              dll_en,
  output logic              ram_zz
);
  logic low_power;
  logic code_is_reserved;
  logic run_code;

  assign low_power        = core_nap || core_sleep;
  assign code_is_reserved = code_reserved(ratio_code);
  assign req_halves       = code_halves(ratio_code);
  assign run_code         = (req_halves != '0);
  assign req_ram_on       = !(clk_stop_en && low_power);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_en <= 1'b0;
      ram_zz <= 1'b0;
    end else begin
      dll_en <= run_code;
      ram_zz <= sleep_pin_en && low_power;
    end
  end

  p_dll_off_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_code == 3'b000) |=> !dll_en);
  p_reserved_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_is_reserved |=> !dll_en);
  p_zz_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_pin_en && (core_nap || core_sleep)) |=> ram_zz);
  p_zz_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_pin_en && (core_nap || core_sleep)) |=> !ram_zz);
endmodule

// File: rtl/hcg_divider.sv
module hcg_divider
  import hcg_pkg::*;
#(
  parameter int RAM_CLKS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  halves_t             req_halves,
  input  logic                req_ram_on,
  output logic                sync_clk,
  output logic [RAM_CLKS-1:0] ram_clk
);
  halves_t cur_p, ph;
  logic    cur_on;

  // Period boundary at this rising edge, or at the following falling edge.
  logic at_start, at_mid;
  assign at_start = (ph == '0);
  assign at_mid   = (cur_p > halves_t'(1)) && (ph == cur_p - halves_t'(1));

  halves_t p1, p2, i2, ph_nxt;
  logic    on1, on2, lvl1, lvl2;

  always_comb begin
    p1     = at_start ? req_halves : cur_p;
    on1    = at_start ? req_ram_on : cur_on;
    p2     = (at_start || at_mid) ? req_halves : cur_p;
    on2    = (at_start || at_mid) ? req_ram_on : cur_on;
    i2     = at_mid ? halves_t'(0) : next_idx(p1, ph);
    ph_nxt = next_idx(p2, i2);
    lvl1   = level_at(p1, ph);
    lvl2   = level_at(p2, i2);
  end

  logic sync_hi_q, sync_lo_pre, sync_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_p       <= '0;
      cur_on      <= 1'b0;
      ph          <= '0;
      sync_hi_q   <= 1'b0;
      sync_lo_pre <= 1'b0;
    end else begin
      cur_p       <= p2;
      cur_on      <= on2;
      ph          <= ph_nxt;
      sync_hi_q   <= lvl1;
      sync_lo_pre <= lvl2;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sync_lo_q <= 1'b0;
    else        sync_lo_q <= sync_lo_pre;
  end

  assign sync_clk = clk ? sync_hi_q : sync_lo_q;

  for (genvar g = 0; g < RAM_CLKS; g++) begin : g_ram
    logic hi_q, lo_pre, lo_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q   <= 1'b0;
        lo_pre <= 1'b0;
      end else begin
        hi_q   <= lvl1 && on1;
        lo_pre <= lvl2 && on2;
      end
    end
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) lo_q <= 1'b0;
      else        lo_q <= lo_pre;
    end
    assign ram_clk[g] = clk ? hi_q : lo_q;
  end

  p_phase_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_p != '0) |-> (ph < cur_p));
  p_ratio_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_p) |-> $past(at_start || at_mid));
  p_gate_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_on) |-> $past(at_start || at_mid));
  p_stopped_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_p == '0) |-> (ph == '0));
endmodule

// File: rtl/halfratio_clkgen.sv
module halfratio_clkgen
  import hcg_pkg::*;
#(
  parameter int RAM_CLKS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          ratio_code,
  input  logic                clk_stop_en,
  input  logic                sleep_pin_en,
  input  logic                core_nap,
  input  logic                core_sleep,
  output logic [RAM_CLKS-1:0] ram_clk,
  output logic                sync_clk,
  output logic                dll_en,
  output logic                ram_zz
);
  halves_t req_halves;
  logic    req_ram_on;

  hcg_pwr_ctrl u_pwr (
    .clk          (clk),
    .rst_n        (rst_n),
    .ratio_code   (ratio_code),
    .clk_stop_en  (clk_stop_en),
    .sleep_pin_en (sleep_pin_en),
    .core_nap     (core_nap),
    .core_sleep   (core_sleep),
    .req_halves   (req_halves),
    .req_ram_on   (req_ram_on),
    .dll_en       (dll_en),
    .ram_zz       (ram_zz)
  );

  hcg_divider #(.RAM_CLKS(RAM_CLKS)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_halves (req_halves),
    .req_ram_on (req_ram_on),
    .sync_clk   (sync_clk),
    .ram_clk    (ram_clk)
  );
endmodule

// File: tb/halfratio_clkgen_tb_top.sv
`timescale 1ns/1ps
module halfratio_clkgen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_code = 3'b000;
  logic       clk_stop_en = 1'b0, sleep_pin_en = 1'b0, core_nap = 1'b0, core_sleep = 1'b0;
  logic [1:0] ram_clk;
  logic       sync_clk, dll_en, ram_zz;

  halfratio_clkgen dut_i (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .clk_stop_en(clk_stop_en),
    .sleep_pin_en(sleep_pin_en), .core_nap(core_nap), .core_sleep(core_sleep),
    .ram_clk(ram_clk), .sync_clk(sync_clk), .dll_en(dll_en), .ram_zz(ram_zz));

  always #2 clk = ~clk;  // 250 MHz

  int    n_checks = 0, n_errors = 0;
  string tag = "R8";

  // Reference model state
  int m_p = 0, m_idx = 0;
  bit m_en = 0, e_sync = 0, e_ram = 0, e_dll = 0, e_zz = 0;

  function automatic int ref_halves(input logic [2:0] c);
    int r;
    r = 0;
    if (c == 3'd1) r = 2;
    else if (c == 3'd2) r = 3;
    else if (c == 3'd4 || c == 3'd5 || c == 3'd6) r = c;
    return r;
  endfunction

  task automatic model_half();
    if (!rst_n) begin
      m_p = 0; m_idx = 0; m_en = 0; e_sync = 0; e_ram = 0;
    end else begin
      if (m_idx == 0) begin
        m_p  = ref_halves(ratio_code);
        m_en = !(clk_stop_en && (core_nap || core_sleep));
      end
      e_sync = (m_p != 0) && (m_idx < m_p / 2);
      e_ram  = e_sync && m_en;
      m_idx  = (m_p == 0) ? 0 : (m_idx + 1) % m_p;
    end
  endtask

  task automatic check(input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("sync_clk", sync_clk, e_sync);
    check("ram_clk0", ram_clk[0], e_ram);
    check("ram_clk1", ram_clk[1], e_ram);
    check("dll_en", dll_en, e_dll);
    check("ram_zz", ram_zz, e_zz);
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin e_dll = 0; e_zz = 0; end
    else begin
      e_dll = ref_halves(ratio_code) != 0;
      e_zz  = sleep_pin_en && (core_nap || core_sleep);
    end
    model_half();
    #1 compare_all();
    @(negedge clk);
    model_half();
    #1 compare_all();
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #200000;
    n_errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    // R8: reset with a running code requested
    tag = "R8"; ratio_code = 3'b101; sleep_pin_en = 1; core_nap = 1;
    run(4);
    core_nap = 0; sleep_pin_en = 0;
    rst_n = 1;
    // R1: each valid ratio
    tag = "R1";
    foreach (ratio_code[i]) ;
    ratio_code = 3'b001; run(12);
    ratio_code = 3'b010; run(12);
    ratio_code = 3'b100; run(12);
    ratio_code = 3'b101; run(15);
    ratio_code = 3'b110; run(15);
    // R2: stopped
    tag = "R2"; ratio_code = 3'b000; run(8);
    ratio_code = 3'b010; run(6);
    // R3: reserved codes
    tag = "R3"; ratio_code = 3'b011; run(8);
    ratio_code = 3'b111; run(8);
    // R5: changes at irregular intervals
    tag = "R5";
    for (int k = 0; k < 40; k++) begin
      case (k % 6)
        0: ratio_code = 3'b101;
        1: ratio_code = 3'b010;
        2: ratio_code = 3'b110;
        3: ratio_code = 3'b001;
        4: ratio_code = 3'b100;
        default: ratio_code = 3'b011;
      endcase
      run(1 + (k * 7) % 5);
    end
    // R6: ungated equality
    tag = "R6"; ratio_code = 3'b110; run(12);
    // R4: clock stop during nap and sleep
    tag = "R4"; ratio_code = 3'b101; clk_stop_en = 1;
    core_nap = 1; run(14); core_nap = 0; run(10);
    core_sleep = 1; run(3); ratio_code = 3'b010; run(9); core_sleep = 0; run(10);
    // R9: stop disabled, low-power ignored for clocks
    tag = "R9"; clk_stop_en = 0; core_nap = 1; run(12); core_nap = 0;
    // R7: sleep pin
    tag = "R7"; sleep_pin_en = 1; core_sleep = 1; run(4); core_sleep = 0; run(2);
    core_nap = 1; run(3); sleep_pin_en = 0; run(3); core_nap = 0; run(3);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule